// File: doc/BRIEF.md
# Zero-Cross Scan Clock Multiplier

This block turns a motor's zero-cross signal into a scan tick that runs 36 times faster, so that a waveform table can be stepped through in lock with the rotor. The raw zero-cross input passes through a two-flop synchroniser, and its rising edges mark the period boundaries. The block counts system clocks between consecutive rising edges. At each new edge, the period just measured sets the tick spacing for the period that begins.

The tick spacing is the measured period split into 36 slots. The integer part of the spacing is applied on every tick. The remainder is spread across the slots by a fractional accumulator, so tick n of a period falls floor(n*P/36) clocks after tick 0. This puts exactly 36 ticks in each steady period. The tick phase restarts at every zero-cross edge, and the spacing is derived again from the latest period, so the scan follows changes in motor speed. No ticks are issued until one full period has been measured.

The division by 36 is carried out while the period is being counted: a slot remainder and a quotient are kept alongside the counter. Quotient and remainder are therefore ready on the very edge that ends the period.

Top module: `zc_scan_mult`

## Requirements
- R1: While reset is asserted and on the first cycle after it, scan_tick, zc_edge and period_valid are all low. After reset, a fresh period measurement is required before ticks resume.
- R2: zc_edge is a one-cycle pulse, high in the second cycle after the cycle in which zc_raw is first sampled high. A falling edge of zc_raw produces no pulse.
- R3: period_valid stays low until the second zc_edge after reset. It goes high in the cycle after that pulse and remains high until reset.
- R4: scan_tick is never high while period_valid is low.
- R5: When period_valid is high after an edge, tick 0 of the new period appears in the cycle right after the zc_edge pulse.
- R6: With P the number of clocks between the two previous zc_edge pulses, tick n (n = 0..35) appears 1 + floor(n*P/36) cycles after the zc_edge pulse. In a steady period this gives exactly 36 ticks.
- R7: The spacing is recomputed at every zc_edge from the period that just ended. A tick whose slot would fall after the next zc_edge is dropped, and the tick sequence restarts at that edge.
- R8: If P is below 36, the spacing is clamped to one clock. Tick n then appears 1 + n cycles after the edge, one tick per cycle, until the next edge.
- R9: The period count saturates at 2^CNT_W - 1. A longer gap between edges is treated as a period of exactly that length.
- R10: No more than 36 ticks appear between one zc_edge and the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| zc_raw | input | 1 | Unsynchronised zero-cross input |
| scan_tick | output | 1 | One-cycle scan step pulse, 36 per zero-cross period |
| zc_edge | output | 1 | One-cycle pulse on a synchronised rising zero-cross edge |
| period_valid | output | 1 | High once a full period has been measured |

## Verification
The bench builds the block with CNT_W = 10 and SLOTS kept at 36. The narrower counter puts saturation at 1023 clocks, so gaps of 1500 and 2000 clocks can test the clamped measurement within a short run. A sweep over every period from 2 to 200 clocks covers the below-36 clamp and every remainder class of the division by 36, and each tick is compared with the floor(n*P/36) slot offset. A scripted list of unequal periods exercises speed-up and slow-down, where slots beyond the next edge must be dropped. A reset in the middle of the run then shows that two fresh edges are needed again.

// File: rtl/zc_scan_pkg.sv
package zc_scan_pkg;

    parameter int unsigned ZC_CNT_W_DEF = 20;
    parameter int unsigned ZC_SLOTS_DEF = 36;

    typedef enum logic [1:0] {
        TG_IDLE = 2'd0,
        TG_RUN  = 2'd1,
        TG_HOLD = 2'd2
    } tg_state_e;

endpackage

// File: rtl/zc_edge_sync.sv
module zc_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic zc_raw_i,
    output logic zc_edge_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = zc_raw_i;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign zc_edge_o = r_q.s2 & ~r_q.s3;

endmodule

// File: rtl/zc_period_div.sv
module zc_period_div #(
    parameter int unsigned CNT_W = 20,
    parameter int unsigned SLOTS = 36,
    localparam int unsigned RW   = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_i,
    output logic             meas_ok_o,
    output logic [CNT_W-1:0] quo_o,
    output logic [RW-1:0]    rem_o,
    output logic             valid_o
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [RW-1:0]    REM_LAST = RW'(SLOTS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] quo;
        logic [RW-1:0]    rem;
        logic             seen;
        logic             valid;
    } meas_t;

    meas_t m_q, m_d;

    always_comb begin
        m_d = m_q;
        if (edge_i) begin
            // the edge cycle itself is clock number one of the new period
            m_d.cnt   = CNT_W'(1);
            m_d.quo   = '0;
            m_d.rem   = RW'(1);
            m_d.seen  = 1'b1;
            m_d.valid = m_q.valid | m_q.seen;
        end else if (m_q.cnt != CNT_MAX) begin
            m_d.cnt = m_q.cnt + 1'b1;
            if (m_q.rem == REM_LAST) begin
                m_d.rem = '0;
                m_d.quo = m_q.quo + 1'b1;
            end else begin
                m_d.rem = m_q.rem + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign meas_ok_o = m_q.seen;
    assign quo_o     = m_q.quo;
    assign rem_o     = m_q.rem;
    assign valid_o   = m_q.valid;

endmodule

// File: rtl/zc_tick_gen.sv
module zc_tick_gen
    import zc_scan_pkg::*;
#(
    parameter int unsigned CNT_W = 20,
    parameter int unsigned SLOTS = 36,
    localparam int unsigned RW   = $clog2(SLOTS),
    localparam int unsigned SW   = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_i,
    input  logic             meas_ok_i,
    input  logic [CNT_W-1:0] quo_i,
    input  logic [RW-1:0]    rem_i,
    output logic             tick_o
);

    localparam logic [CNT_W-1:0] POS_MAX  = '1;
    localparam logic [SW-1:0]    NT_LAST  = SW'(SLOTS);
    localparam logic [RW:0]      FRAC_LIM = (RW+1)'(SLOTS);

    typedef struct packed {
        tg_state_e        st;
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] tgt;
        logic [CNT_W-1:0] intv;
        logic [RW-1:0]    frac;
        logic [RW-1:0]    srem;
        logic [SW-1:0]    nt;
        logic             tick;
    } tg_t;

    tg_t t_q, t_d;
    logic [RW:0] fsum;
    logic        short_p;

    always_comb begin
        t_d      = t_q;
        t_d.tick = 1'b0;
        fsum     = {1'b0, t_q.frac} + {1'b0, t_q.srem};
        short_p  = (quo_i == '0);
        if (edge_i) begin
            if (meas_ok_i) begin
                // slot 0 sits on the edge; spacing clamps to one clock when short
                t_d.intv = short_p ? CNT_W'(1) : quo_i;
                t_d.srem = short_p ? '0 : rem_i;
                t_d.tgt  = short_p ? CNT_W'(1) : quo_i;
                t_d.frac = short_p ? '0 : rem_i;
                t_d.pos  = CNT_W'(1);
                t_d.nt   = SW'(1);
                t_d.tick = 1'b1;
                t_d.st   = (SW'(1) == NT_LAST) ? TG_HOLD : TG_RUN;
            end else begin
                t_d.st = TG_IDLE;
            end
        end else if (t_q.st == TG_RUN) begin
            t_d.pos = (t_q.pos == POS_MAX) ? t_q.pos : t_q.pos + 1'b1;
            if (t_q.pos == t_q.tgt) begin
                t_d.tick = 1'b1;
                t_d.nt   = t_q.nt + 1'b1;
                if (fsum >= FRAC_LIM) begin
                    t_d.frac = RW'(fsum - FRAC_LIM);
                    t_d.tgt  = t_q.tgt + t_q.intv + 1'b1;
                end else begin
                    t_d.frac = RW'(fsum);
                    t_d.tgt  = t_q.tgt + t_q.intv;
                end
                if (t_d.nt == NT_LAST) begin
                    t_d.st = TG_HOLD;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '{st: TG_IDLE, default: '0};
        end else begin
            t_q <= t_d;
        end
    end

    assign tick_o = t_q.tick;

endmodule

// File: rtl/zc_scan_mult.sv
module zc_scan_mult #(
    parameter int unsigned CNT_W = zc_scan_pkg::ZC_CNT_W_DEF,
    parameter int unsigned SLOTS = zc_scan_pkg::ZC_SLOTS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic zc_raw,
    output logic scan_tick,
    output logic zc_edge,
    output logic period_valid
);

    localparam int unsigned RW = $clog2(SLOTS);

    logic             edge_w;
    logic             meas_ok_w;
    logic [CNT_W-1:0] quo_w;
    logic [RW-1:0]    rem_w;

    zc_edge_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .zc_raw_i  (zc_raw),
        .zc_edge_o (edge_w)
    );

    zc_period_div #(
        .CNT_W (CNT_W),
        .SLOTS (SLOTS)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .edge_i    (edge_w),
        .meas_ok_o (meas_ok_w),
        .quo_o     (quo_w),
        .rem_o     (rem_w),
        .valid_o   (period_valid)
    );

    zc_tick_gen #(
        .CNT_W (CNT_W),
        .SLOTS (SLOTS)
    ) u_tick (
        .clk       (clk),
        .rst       (rst),
        .edge_i    (edge_w),
        .meas_ok_i (meas_ok_w),
        .quo_i     (quo_w),
        .rem_i     (rem_w),
        .tick_o    (scan_tick)
    );

    assign zc_edge = edge_w;

endmodule

// File: rtl/zc_scan_mult_chk.sv
module zc_scan_mult_chk #(
    parameter int unsigned SLOTS = 36,
    localparam int unsigned CW   = $clog2(SLOTS + 2)
) (
    input logic clk,
    input logic rst,
    input logic scan_tick,
    input logic zc_edge,
    input logic period_valid
);

    logic [CW-1:0] tick_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt_q <= '0;
        end else if (zc_edge) begin
            tick_cnt_q <= '0;
        end else if (scan_tick) begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
        end
    end

    assert_edge_single_R2: assert property (@(posedge clk) disable iff (rst)
        zc_edge |=> !zc_edge);

    assert_valid_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        period_valid |=> period_valid);

    assert_valid_after_edge_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(period_valid) |-> $past(zc_edge));

    assert_no_tick_unmeasured_R4: assert property (@(posedge clk) disable iff (rst)
        scan_tick |-> period_valid);

    assert_first_tick_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(zc_edge) && period_valid) |-> scan_tick);

    assert_slot_limit_R10: assert property (@(posedge clk) disable iff (rst)
        (int'(tick_cnt_q) + (scan_tick ? 1 : 0)) <= int'(SLOTS));

endmodule

bind zc_scan_mult zc_scan_mult_chk #(.SLOTS(SLOTS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .scan_tick    (scan_tick),
    .zc_edge      (zc_edge),
    .period_valid (period_valid)
);

// File: tb/zc_scan_mult_bench.sv
module zc_scan_mult_bench;

    localparam int CNT_W = 10;
    localparam int SLOTS = 36;
    localparam int PMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic zc_raw = 1'b0;
    logic scan_tick, zc_edge, period_valid;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    int rise_a = -100;
    int rise_b = -100;

    zc_scan_mult #(.CNT_W(CNT_W), .SLOTS(SLOTS)) u_zc_scan_mult (
        .clk          (clk),
        .rst          (rst),
        .zc_raw       (zc_raw),
        .scan_tick    (scan_tick),
        .zc_edge      (zc_edge),
        .period_valid (period_valid)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            if (n_fail <= 25)
                $display("FAIL %s %s at cycle %0d: got %0d expected %0d",
                         tag, what, cyc, act, exp);
        end
    endtask

    function automatic int slot_off(input int n, input int pp);
        if (pp < SLOTS) return n;
        return (n * pp) / SLOTS;
    endfunction

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic run_period(input int p);
        int h;
        h = (p / 2 < 1) ? 1 : p / 2;
        zc_raw = 1'b1;
        rise_b = rise_a;
        rise_a = cyc;
        step(h);
        zc_raw = 1'b0;
        step(p - h);
    endtask

    // monitor state
    bit have_e, active, chk_valid_next;
    int e_k, pp, slot, nt;

    always @(negedge clk) begin
        int off, plen, expc;
        bit exp_e, exp_t;
        string tg;
        if (rst) begin
            have_e = 0; active = 0; slot = 0; nt = 0; pp = 0; chk_valid_next = 0;
        end else if (!done) begin
            exp_e = (cyc == rise_a + 2) || (cyc == rise_b + 2);
            if (exp_e || zc_edge)
                chk(exp_e == zc_edge, "R2", "zc_edge", int'(zc_edge), int'(exp_e));
            if (chk_valid_next) begin
                chk(period_valid == active, "R3", "period_valid after edge",
                    int'(period_valid), int'(active));
                chk_valid_next = 0;
            end
            off = cyc - e_k;
            exp_t = active && (slot < SLOTS) && (off == 1 + slot_off(slot, pp));
            if (exp_t || scan_tick) begin
                if (!active) tg = "R4";
                else if (slot == 0) tg = "R5";
                else if (pp < SLOTS) tg = "R8";
                else if (pp == PMAX) tg = "R9";
                else tg = "R6";
                chk(exp_t == scan_tick, tg, "scan_tick", int'(scan_tick), int'(exp_t));
            end
            if (exp_t) slot++;
            if (scan_tick) nt++;
            if (zc_edge) begin
                chk(period_valid == active, "R3", "period_valid at edge",
                    int'(period_valid), int'(active));
                if (active) begin
                    plen = cyc - e_k;
                    expc = 0;
                    for (int n = 0; n < SLOTS; n++)
                        if (1 + slot_off(n, pp) <= plen) expc++;
                    if (plen != pp && !(pp == PMAX && plen > PMAX)) tg = "R7";
                    else if (pp == PMAX) tg = "R9";
                    else if (pp < SLOTS) tg = "R8";
                    else tg = "R6";
                    chk(nt == expc, tg, "ticks per period", nt, expc);
                    chk(nt <= SLOTS, "R10", "tick ceiling", nt, SLOTS);
                end
                if (have_e) begin
                    pp = (cyc - e_k > PMAX) ? PMAX : cyc - e_k;
                    active = 1;
                end
                have_e = 1;
                e_k = cyc;
                slot = 0;
                nt = 0;
                chk_valid_next = 1;
            end
        end
    end

    task automatic check_reset_state(input string what);
        @(negedge clk);
        chk(scan_tick == 0, "R1", {what, " scan_tick"}, int'(scan_tick), 0);
        chk(zc_edge == 0, "R1", {what, " zc_edge"}, int'(zc_edge), 0);
        chk(period_valid == 0, "R1", {what, " period_valid"}, int'(period_valid), 0);
        @(posedge clk);
        #2;
    endtask

    initial begin
        int plist[12] = '{400, 200, 90, 300, 37, 35, 36, 72, 73, 1000, 500, 120};
        int slist[6]  = '{1500, 1023, 1024, 700, 2000, 2000};
        rst = 1'b1;
        step(4);
        check_reset_state("initial reset");
        rst = 1'b0;
        step(1);
        chk(period_valid == 0, "R1", "valid after release", int'(period_valid), 0);
        step(10);
        // R6/R8: sweep every period length, three periods each
        for (int p = 2; p <= 200; p++)
            for (int k = 0; k < 3; k++) run_period(p);
        // R7: speed changes
        foreach (plist[i]) run_period(plist[i]);
        // R9: gaps beyond the counter range
        foreach (slist[i]) run_period(slist[i]);
        step(20);
        // R1/R3: reset mid-run, measurement must restart
        rst = 1'b1;
        step(3);
        check_reset_state("mid-run reset");
        rst = 1'b0;
        step(8);
        chk(period_valid == 0, "R3", "valid before edges", int'(period_valid), 0);
        for (int k = 0; k < 4; k++) run_period(80);
        step(30);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule